// File: doc/BRIEF.md
# PLL Reset and Lock Sequencer

This block drives the bring-up of a phase-locked loop. On a start request it holds the PLL in software reset for a fixed number of timer ticks, with the run control held low. It then issues a one-cycle strobe that loads the voltage-reference setting and raises the run control. After that it polls the core in two phases: first the ready status, then the lock status.

Each poll phase reads its status bit at most a fixed number of times. The reads are a programmable number of ticks apart. The lock phase begins only after the ready phase has succeeded. A lock seen within budget ends in the done state with the PLL left running. A budget exhausted in either phase ends in the failure state with the run control dropped. A stop request at any time returns the block to idle with every control low.

Both status bits come from another clock domain. They pass through a synchronizer of at least two flops before the sequencer looks at them. The timer tick is a single-cycle pulse that is synchronous to the block clock.

Top module: `pll_seq_ctrl`

## Requirements
- R1: After reset, all five outputs (sw_rst, pll_run, vref_wr, seq_done, lock_fail) are low.
- R2: A go_req sampled without halt_req, while idle, done or failed, raises sw_rst on the next cycle with pll_run low. sw_rst falls in the cycle after the edge that samples the RST_TICKS-th tick.
- R3: When sw_rst falls, vref_wr is high for exactly that one cycle with pll_run low. pll_run rises on the following cycle.
- R4: core_ready and core_lock are seen SYNC_STAGES cycles late. The first ready read happens in the first cycle of the ready phase. Each failed read is followed by a wait of POLL_GAP ticks before the next read. core_lock is ignored until a ready read has succeeded.
- R5: If POLL_TRIES ready reads all see 0, lock_fail rises and pll_run falls.
- R6: A successful lock read (first read in the phase, gap rules as in R4) raises seq_done. pll_run stays high while seq_done is high.
- R7: If POLL_TRIES lock reads all see 0, lock_fail rises and pll_run falls.
- R8: halt_req sampled in any state clears all outputs on the next cycle. halt_req wins over a simultaneous go_req.
- R9: go_req while a sequence is running (reset, strobe or polling) has no effect.
- R10: sw_rst and pll_run are never high together, and seq_done and lock_fail are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go_req | input | 1 | Request to run the bring-up sequence |
| halt_req | input | 1 | Request to stop and return to idle |
| tick | input | 1 | One-cycle timer pulse (time base) |
| core_ready | input | 1 | Ready status from the PLL core, asynchronous |
| core_lock | input | 1 | Lock status from the PLL core, asynchronous |
| sw_rst | output | 1 | Software reset control to the PLL |
| pll_run | output | 1 | Start/run control to the PLL |
| vref_wr | output | 1 | One-cycle voltage-reference configuration strobe |
| seq_done | output | 1 | Sequence ended with lock |
| lock_fail | output | 1 | Sequence ended without ready or lock |

## Verification
The hardest behaviour to reach is core_lock held high while core_ready stays low. A careless design would leave the ready phase early on the lock bit, but only the failure at the end of the ready budget shows the difference. The stimulus pins lock at 1 and ready at 0 through a whole budget and checks that the run ends failed. Stop and restart requests are also timed to land inside the reset window and inside the poll gaps, where the tick counter and the try counter both hold partial values.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
   typedef enum logic [2:0] {
      SEQ_IDLE  = 3'd0,
      SEQ_RESET = 3'd1,
      SEQ_VREF  = 3'd2,
      SEQ_RDY   = 3'd3,
      SEQ_LCK   = 3'd4,
      SEQ_DONE  = 3'd5,
      SEQ_FAIL  = 3'd6
   } seq_state_e;
endpackage

// File: rtl/pll_seq_sync.sv
module pll_seq_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   logic [STAGES-1:0][WIDTH-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= '0;
      else        stg <= {stg[STAGES-2:0], din};
   end

   assign dout = stg[STAGES-1];
endmodule

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             tick,
   output logic [CNT_W-1:0] cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt <= '0;
      else if (load)              cnt <= load_val;
      else if (tick && cnt != '0) cnt <= cnt - 1'b1;
   end
endmodule

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm
   import pll_seq_pkg::*;
#(
   parameter int RST_TICKS  = 10,
   parameter int POLL_TRIES = 15,
   parameter int POLL_GAP   = 1000,
   parameter int CNT_W      = 10,
   parameter int TRY_W      = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go_req,
   input  logic             halt_req,
   input  logic             tick,
   input  logic             rdy_s,
   input  logic             lck_s,
   input  logic [CNT_W-1:0] cnt,
   output logic             tm_load,
   output logic [CNT_W-1:0] tm_val,
   output logic             sw_rst,
   output logic             pll_run,
   output logic             vref_wr,
   output logic             seq_done,
   output logic             lock_fail
);
   localparam logic [CNT_W-1:0] RST_VAL  = CNT_W'(RST_TICKS);
   localparam logic [CNT_W-1:0] GAP_VAL  = CNT_W'(POLL_GAP);
   localparam logic [TRY_W-1:0] LAST_TRY = TRY_W'(POLL_TRIES - 1);

   seq_state_e       st, nxt;
   logic [TRY_W-1:0] tries;
   logic             try_clr, try_inc;
   logic             read_now, bit_seen;

   assign read_now = (cnt == '0);
   assign bit_seen = (st == SEQ_RDY) ? rdy_s : lck_s;

   always_comb begin
      nxt     = st;
      tm_load = 1'b0;
      tm_val  = '0;
      try_clr = 1'b0;
      try_inc = 1'b0;
      if (halt_req) begin
         nxt = SEQ_IDLE;
      end else begin
         unique case (st)
            SEQ_IDLE, SEQ_DONE, SEQ_FAIL: begin
               if (go_req) begin
                  nxt     = SEQ_RESET;
                  tm_load = 1'b1;
                  tm_val  = RST_VAL;
               end
            end
            SEQ_RESET: begin
               if (tick && cnt == CNT_W'(1)) nxt = SEQ_VREF;
            end
            SEQ_VREF: begin
               nxt     = SEQ_RDY;
               tm_load = 1'b1;
               try_clr = 1'b1;
            end
            SEQ_RDY, SEQ_LCK: begin
               if (read_now) begin
                  if (bit_seen) begin
                     nxt     = (st == SEQ_RDY) ? SEQ_LCK : SEQ_DONE;
                     tm_load = 1'b1;
                     try_clr = 1'b1;
                  end else if (tries == LAST_TRY) begin
                     nxt = SEQ_FAIL;
                  end else begin
                     try_inc = 1'b1;
                     tm_load = 1'b1;
                     tm_val  = GAP_VAL;
                  end
               end
            end
            default: nxt = SEQ_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= SEQ_IDLE;
         tries <= '0;
      end else begin
         st <= nxt;
         if (try_clr)      tries <= '0;
         else if (try_inc) tries <= tries + 1'b1;
      end
   end

   assign sw_rst    = (st == SEQ_RESET);
   assign vref_wr   = (st == SEQ_VREF);
   assign pll_run   = (st == SEQ_RDY) || (st == SEQ_LCK) || (st == SEQ_DONE);
   assign seq_done  = (st == SEQ_DONE);
   assign lock_fail = (st == SEQ_FAIL);
endmodule

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl #(
   parameter int RST_TICKS   = 10,
   parameter int POLL_TRIES  = 15,
   parameter int POLL_GAP    = 1000,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go_req,
   input  logic halt_req,
   input  logic tick,
   input  logic core_ready,
   input  logic core_lock,
   output logic sw_rst,
   output logic pll_run,
   output logic vref_wr,
   output logic seq_done,
   output logic lock_fail
);
   localparam int CNT_MAX = (RST_TICKS > POLL_GAP) ? RST_TICKS : POLL_GAP;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);
   localparam int TRY_W   = $clog2(POLL_TRIES + 1);

   generate
      if (RST_TICKS < 1)   begin : g_bad_rst   $error("RST_TICKS must be at least 1");   end
      if (POLL_TRIES < 1)  begin : g_bad_tries $error("POLL_TRIES must be at least 1");  end
      if (POLL_GAP < 1)    begin : g_bad_gap   $error("POLL_GAP must be at least 1");    end
      if (SYNC_STAGES < 2) begin : g_bad_sync  $error("SYNC_STAGES must be at least 2"); end
   endgenerate

   logic [1:0]       stat_s;
   logic [CNT_W-1:0] cnt, tm_val;
   logic             tm_load;

   pll_seq_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({core_lock, core_ready}),
      .dout (stat_s)
   );

   pll_seq_timer #(.CNT_W(CNT_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (tm_load),
      .load_val(tm_val),
      .tick    (tick),
      .cnt     (cnt)
   );

   pll_seq_fsm #(
      .RST_TICKS (RST_TICKS),
      .POLL_TRIES(POLL_TRIES),
      .POLL_GAP  (POLL_GAP),
      .CNT_W     (CNT_W),
      .TRY_W     (TRY_W)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .go_req   (go_req),
      .halt_req (halt_req),
      .tick     (tick),
      .rdy_s    (stat_s[0]),
      .lck_s    (stat_s[1]),
      .cnt      (cnt),
      .tm_load  (tm_load),
      .tm_val   (tm_val),
      .sw_rst   (sw_rst),
      .pll_run  (pll_run),
      .vref_wr  (vref_wr),
      .seq_done (seq_done),
      .lock_fail(lock_fail)
   );
endmodule

// File: rtl/pll_seq_chk.sv
module pll_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic go_req,
   input logic halt_req,
   input logic sw_rst,
   input logic pll_run,
   input logic vref_wr,
   input logic seq_done,
   input logic lock_fail
);
   // R2
   enter_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (go_req && !halt_req && !sw_rst && !vref_wr && (!pll_run || seq_done)) |=> (sw_rst && !pll_run));

   // R3
   strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vref_wr && !halt_req) |=> (!vref_wr && pll_run));

   // R3
   run_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pll_run) |-> $past(vref_wr));

   // R5
   fail_from_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_fail) |-> ($past(pll_run) && !pll_run));

   // R6
   done_keeps_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seq_done |-> pll_run);

   // R8
   halt_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halt_req |=> !(sw_rst || pll_run || vref_wr || seq_done || lock_fail));

   // R10
   rst_run_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(sw_rst && pll_run));

   // R10
   done_fail_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(seq_done && lock_fail));
endmodule

bind pll_seq_ctrl pll_seq_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .go_req   (go_req),
   .halt_req (halt_req),
   .sw_rst   (sw_rst),
   .pll_run  (pll_run),
   .vref_wr  (vref_wr),
   .seq_done (seq_done),
   .lock_fail(lock_fail)
);

// File: tb/pll_seq_ctrl_bench.sv
`timescale 1ns/1ps
module pll_seq_ctrl_bench;
   localparam int RST_T = 10;
   localparam int TRIES = 15;
   localparam int GAP   = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic go_req = 1'b0, halt_req = 1'b0, tick = 1'b0;
   logic core_ready = 1'b0, core_lock = 1'b0;
   logic sw_rst, pll_run, vref_wr, seq_done, lock_fail;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   bit ended = 1'b0;

   always #2 clk = ~clk;

   pll_seq_ctrl #(.RST_TICKS(RST_T), .POLL_TRIES(TRIES), .POLL_GAP(GAP), .SYNC_STAGES(2)) u_pll_seq_ctrl (
      .clk(clk), .rst_n(rst_n), .go_req(go_req), .halt_req(halt_req), .tick(tick),
      .core_ready(core_ready), .core_lock(core_lock),
      .sw_rst(sw_rst), .pll_run(pll_run), .vref_wr(vref_wr),
      .seq_done(seq_done), .lock_fail(lock_fail)
   );

   // Reference model: phase codes 0 idle,1 reset,2 strobe,3 ready poll,4 lock poll,5 done,6 failed
   int ph = 0, ticks_left = 0, reads = 0;
   bit rdy_hist[$];
   bit lck_hist[$];

   always @(posedge clk) begin
      bit rv, lv;
      int nph, ntl, nrd;
      if (!rst_n) begin
         ph = 0; ticks_left = 0; reads = 0;
         rdy_hist = '{1'b0, 1'b0};
         lck_hist = '{1'b0, 1'b0};
      end else begin
         rv = rdy_hist[0]; lv = lck_hist[0];
         nph = ph; nrd = reads;
         ntl = (tick && ticks_left > 0) ? ticks_left - 1 : ticks_left;
         if (halt_req) nph = 0;
         else if (ph == 0 || ph == 5 || ph == 6) begin
            if (go_req) begin nph = 1; ntl = RST_T; end
         end else if (ph == 1) begin
            if (tick && ticks_left == 1) nph = 2;
         end else if (ph == 2) begin
            nph = 3; ntl = 0; nrd = 0;
         end else if (ticks_left == 0) begin
            if ((ph == 3) ? rv : lv) begin nph = ph + 1; ntl = 0; nrd = 0; end
            else if (reads + 1 >= TRIES) nph = 6;
            else begin nrd = reads + 1; ntl = GAP; end
         end
         ph = nph; ticks_left = ntl; reads = nrd;
         void'(rdy_hist.pop_front()); rdy_hist.push_back(core_ready);
         void'(lck_hist.pop_front()); lck_hist.push_back(core_lock);
      end
   end

   task automatic chk(string req, string what, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %b expected %b at cycle %0d", req, what, act, exp, cyc);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   // Per-cycle comparison against the model, tick generation, watchdog
   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         chk("R2", "sw_rst",    sw_rst,    ph == 1);
         chk("R3", "vref_wr",   vref_wr,   ph == 2);
         chk("R4", "pll_run",   pll_run,   ph == 3 || ph == 4 || ph == 5);
         chk("R6", "seq_done",  seq_done,  ph == 5);
         chk("R5", "lock_fail", lock_fail, ph == 6);
      end
      tick = (cyc % 3 == 0);
      if (cyc > 150000) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_go();
      @(negedge clk); go_req = 1'b1;
      @(negedge clk); go_req = 1'b0;
   endtask

   initial begin
      int k;
      idle(3);
      // R1: reset state
      chk("R1", "sw_rst",    sw_rst,    1'b0);
      chk("R1", "pll_run",   pll_run,   1'b0);
      chk("R1", "vref_wr",   vref_wr,   1'b0);
      chk("R1", "seq_done",  seq_done,  1'b0);
      chk("R1", "lock_fail", lock_fail, 1'b0);
      @(negedge clk); rst_n = 1'b1;
      idle(2);

      // Normal bring-up: R2, R3, R6
      pulse_go();
      chk("R2", "sw_rst after go", sw_rst, 1'b1);
      chk("R2", "pll_run during reset", pll_run, 1'b0);
      k = 0;
      while (sw_rst && k < 100) begin @(negedge clk); k++; end
      chk("R3", "vref_wr at reset release", vref_wr, 1'b1);
      chk("R3", "pll_run during strobe", pll_run, 1'b0);
      @(negedge clk);
      chk("R3", "vref_wr one cycle", vref_wr, 1'b0);
      chk("R3", "pll_run after strobe", pll_run, 1'b1);
      idle(40); core_ready = 1'b1;
      idle(30); core_lock = 1'b1;
      idle(100);
      chk("R6", "seq_done", seq_done, 1'b1);
      chk("R6", "pll_run held", pll_run, 1'b1);

      // Ready never seen: R5 (restart from done also covers R2)
      core_ready = 1'b0; core_lock = 1'b0;
      pulse_go();
      chk("R2", "restart from done", sw_rst, 1'b1);
      idle(500);
      chk("R5", "lock_fail on ready timeout", lock_fail, 1'b1);
      chk("R5", "pll_run dropped", pll_run, 1'b0);

      // Lock held but ready absent: lock must be ignored (R4)
      core_lock = 1'b1;
      pulse_go();
      idle(500);
      chk("R4", "lock ignored before ready", lock_fail, 1'b1);
      chk("R4", "no done without ready", seq_done, 1'b0);

      // Ready but no lock: R7
      core_ready = 1'b1; core_lock = 1'b0;
      pulse_go();
      idle(500);
      chk("R7", "lock_fail on lock timeout", lock_fail, 1'b1);
      chk("R7", "seq_done low", seq_done, 1'b0);

      // Go while busy: R9
      core_ready = 1'b0;
      pulse_go();
      idle(60);
      pulse_go();
      chk("R9", "no restart while polling", sw_rst, 1'b0);
      chk("R9", "run kept while polling", pll_run, 1'b1);
      idle(500);

      // Halt in reset window, halt with go, halt in done: R8
      pulse_go();
      idle(8);
      @(negedge clk); halt_req = 1'b1;
      @(negedge clk); halt_req = 1'b0;
      chk("R8", "sw_rst after halt", sw_rst, 1'b0);
      chk("R8", "lock_fail after halt", lock_fail, 1'b0);
      @(negedge clk); halt_req = 1'b1; go_req = 1'b1;
      @(negedge clk); halt_req = 1'b0; go_req = 1'b0;
      chk("R8", "halt beats go", sw_rst, 1'b0);
      core_ready = 1'b1; core_lock = 1'b1;
      pulse_go();
      idle(200);
      chk("R6", "done with both bits", seq_done, 1'b1);
      @(negedge clk); halt_req = 1'b1;
      @(negedge clk); halt_req = 1'b0;
      chk("R8", "pll_run after halt", pll_run, 1'b0);
      chk("R8", "seq_done after halt", seq_done, 1'b0);
      chk("R10", "no reset with run", sw_rst && pll_run, 1'b0);
      idle(5);
      finish_run();
   end
endmodule